// File: doc/BRIEF.md
# Register Frame Free-List Allocator

This block owns the pool of register frames used by a call mechanism. It tracks every frame as either owned by a caller or sitting in the free pool. An allocate request takes the oldest free frame and returns its number one cycle later. A release request gives a frame back to the pool. Free frames are kept in a circular queue, so they are handed out in strict first-in first-out order. After reset the queue holds every frame in ascending order.

A running count of free frames is always visible. An early-warning overflow trap rises while that count is at or below a threshold parameter. This gives software time to spill frames to memory before the pool runs dry. Releasing a frame that is already free is reported on an error pulse and otherwise ignored. The block does nothing about underflow: a count that climbs back to the full pool raises no trap and no error, and the case is left to software.

Top module: `frame_pool`

## Requirements
- R1: While reset is held and in the first cycle after it, free_cnt equals NUM_FRAMES (256), and ovf_warn, alloc_gnt and rel_err are all 0.
- R2: An allocate request seen at a clock edge while free_cnt is nonzero sets alloc_gnt to 1 after that edge and lowers free_cnt by one, unless a release is accepted at the same edge (R6).
- R3: Frame numbers are handed out in queue order. After reset the order is 0, 1, ..., NUM_FRAMES-1. After that come released frames, in the order they were released. alloc_id is valid while alloc_gnt is 1.
- R4: An allocate request seen while free_cnt is 0 is refused: alloc_gnt is 0 after the edge. This holds even when a release is accepted at the same edge; that release still raises free_cnt to 1.
- R5: Releasing a frame that is in use raises free_cnt by one after the edge. A frame counts as in use from the edge that granted it, so it may be released in the cycle right after its grant.
- R6: An accepted allocate and an accepted release at the same edge (free_cnt nonzero) leave free_cnt unchanged and still grant a frame.
- R7: Releasing a frame that is already free sets rel_err to 1 for one cycle after the edge. It does not change free_cnt, and it does not queue the frame a second time.
- R8: ovf_warn is 1 exactly while free_cnt is at or below WARN_LEVEL (default 4). It changes in the same cycle as free_cnt.
- R9: Returning every frame, so that free_cnt reaches NUM_FRAMES, raises neither ovf_warn nor rel_err. No underflow indication exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request one free frame this cycle |
| alloc_gnt | output | 1 | Registered: a frame was granted at the last edge |
| alloc_id | output | 8 | Registered granted frame number |
| rel_req | input | 1 | Return a frame this cycle |
| rel_id | input | 8 | Frame number being returned |
| rel_err | output | 1 | Registered: last release named a frame that was already free |
| free_cnt | output | 9 | Registered number of free frames |
| ovf_warn | output | 1 | Registered early overflow warning |

## Verification
A wrong head pointer or a stale queue entry shows up at alloc_id on the very next grant, because the bench predicts each frame number from the order of releases. A lost or extra update to the ownership record appears as a wrong rel_err within one cycle of the next release of that frame. A wrong queue entry can also surface much later, as a duplicate frame handed out when the pool drains. Counter mistakes appear on free_cnt and ovf_warn in the same cycle as the faulty edge. The bench compares these outputs after every edge of a full drain and a full refill.

// File: rtl/frame_pool_pkg.sv
package frame_pool_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_DEC  = 2'd1,
    CNT_INC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/fp_ring.sv
module fp_ring #(
  parameter int NUM_FRAMES = 256,
  localparam int ID_W = $clog2(NUM_FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pop,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  output logic [ID_W-1:0] pop_id
);
  localparam logic [ID_W-1:0] LAST = ID_W'(NUM_FRAMES - 1);

  logic [ID_W-1:0] store [NUM_FRAMES];
  logic [ID_W-1:0] head_q, tail_q, rd_mem_q, rd_ptr_q;
  logic            first_lap_q, rd_orig_q;

  // queue storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) store[tail_q] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_mem_q <= store[head_q];
  end

  // on the first lap every slot still holds its own index
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q      <= '0;
      tail_q      <= '0;
      first_lap_q <= 1'b1;
      rd_orig_q   <= 1'b1;
      rd_ptr_q    <= '0;
    end else begin
      if (pop) begin
        rd_orig_q <= first_lap_q;
        rd_ptr_q  <= head_q;
        head_q    <= (head_q == LAST) ? '0 : head_q + 1'b1;
        if (head_q == LAST) first_lap_q <= 1'b0;
      end
      if (push) tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
    end
  end

  assign pop_id = rd_orig_q ? rd_ptr_q : rd_mem_q;

  // R3: once the first lap is over it never comes back without reset
  assert_lap_once_R3: assert property (@(posedge clk) disable iff (rst)
    !first_lap_q |=> !first_lap_q);
endmodule

// File: rtl/fp_owner.sv
module fp_owner #(
  parameter int NUM_FRAMES = 256,
  localparam int ID_W = $clog2(NUM_FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  input  logic [ID_W-1:0] query_id,
  output logic            owned
);
  logic [NUM_FRAMES-1:0] busy_q;

  // clear after set: a frame returned right after its grant ends free
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      if (set_en) busy_q[set_id] <= 1'b1;
      if (clr_en) busy_q[clr_id] <= 1'b0;
    end
  end

  // a grant still being recorded counts as owned (R5)
  assign owned = busy_q[query_id] | (set_en && (set_id == query_id));

  // R3: the queue never hands out a frame that is already owned
  assert_grant_was_free_R3: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !busy_q[set_id]);
endmodule

// File: rtl/fp_level.sv
module fp_level #(
  parameter int NUM_FRAMES = 256,
  parameter int WARN_LEVEL = 4,
  localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] cnt,
  output logic             warn
);
  import frame_pool_pkg::*;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_FRAMES);
  localparam logic [CNT_W-1:0] THR  = CNT_W'(WARN_LEVEL);

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             warn_q;

  always_comb begin
    if (take && !give)      op = CNT_DEC;
    else if (give && !take) op = CNT_INC;
    else                    op = CNT_HOLD;
  end

  always_comb begin
    case (op)
      CNT_DEC: cnt_n = cnt_q - 1'b1;
      CNT_INC: cnt_n = cnt_q + 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= FULL;
      warn_q <= (FULL <= THR);
    end else begin
      cnt_q  <= cnt_n;
      warn_q <= (cnt_n <= THR);
    end
  end

  assign cnt  = cnt_q;
  assign warn = warn_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  // the count moves by one at most, so the warning rises exactly at the threshold
  assert_warn_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_q) |-> cnt_q == THR);
  assert_warn_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_q) |-> cnt_q == THR + 1'b1);
endmodule

// File: rtl/frame_pool.sv
module frame_pool #(
  parameter int NUM_FRAMES = 256,
  parameter int WARN_LEVEL = 4,
  localparam int ID_W  = $clog2(NUM_FRAMES),
  localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  output logic             alloc_gnt,
  output logic [ID_W-1:0]  alloc_id,
  input  logic             rel_req,
  input  logic [ID_W-1:0]  rel_id,
  output logic             rel_err,
  output logic [CNT_W-1:0] free_cnt,
  output logic             ovf_warn
);
  logic take, give, owned;
  logic gnt_q, err_q;

  assign take = alloc_req && (free_cnt != '0);
  assign give = rel_req && owned;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      gnt_q <= take;
      err_q <= rel_req && !owned;
    end
  end

  fp_ring #(.NUM_FRAMES(NUM_FRAMES)) u_ring (
    .clk(clk), .rst(rst), .pop(take), .push(give),
    .push_id(rel_id), .pop_id(alloc_id)
  );

  fp_owner #(.NUM_FRAMES(NUM_FRAMES)) u_owner (
    .clk(clk), .rst(rst), .set_en(gnt_q), .set_id(alloc_id),
    .clr_en(give), .clr_id(rel_id), .query_id(rel_id), .owned(owned)
  );

  fp_level #(.NUM_FRAMES(NUM_FRAMES), .WARN_LEVEL(WARN_LEVEL)) u_level (
    .clk(clk), .rst(rst), .take(take), .give(give),
    .cnt(free_cnt), .warn(ovf_warn)
  );

  assign alloc_gnt = gnt_q;
  assign rel_err   = err_q;

  assert_refuse_empty_R4: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> $past(free_cnt) != '0);
  assert_err_keeps_cnt_R7: assert property (@(posedge clk) disable iff (rst)
    (rel_err && !alloc_gnt) |-> free_cnt == $past(free_cnt));
  assert_room_on_return_R5: assert property (@(posedge clk) disable iff (rst)
    give |-> free_cnt < CNT_W'(NUM_FRAMES));
endmodule

// File: tb/sim_frame_pool.sv
module sim_frame_pool;
  localparam int CLK_P = 10;
  localparam int N     = 256;
  localparam int WL    = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alloc_req = 1'b0;
  logic       rel_req = 1'b0;
  logic [7:0] rel_id = '0;
  logic       alloc_gnt, rel_err, ovf_warn;
  logic [7:0] alloc_id;
  logic [8:0] free_cnt;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  frame_pool u0 (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .alloc_id(alloc_id), .rel_req(rel_req), .rel_id(rel_id),
    .rel_err(rel_err), .free_cnt(free_cnt), .ovf_warn(ovf_warn)
  );

  task automatic chk(string req, string what, int got, int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(bit a, bit r, int id);
    alloc_req = a; rel_req = r; rel_id = 8'(id);
    @(negedge clk);
    alloc_req = 1'b0; rel_req = 1'b0;
  endtask

  task automatic chk_state(string req, int cnt);
    chk(req, "free_cnt", int'(free_cnt), cnt);
    chk("R8", "ovf_warn", int'(ovf_warn), int'(cnt <= WL));
  endtask

  task automatic t_reset();
    chk("R1", "free_cnt", int'(free_cnt), N);
    chk("R1", "ovf_warn", int'(ovf_warn), 0);
    chk("R1", "alloc_gnt", int'(alloc_gnt), 0);
    chk("R1", "rel_err", int'(rel_err), 0);
  endtask

  task automatic t_first_allocs();
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0);
      chk("R2", "alloc_gnt", int'(alloc_gnt), 1);
      chk("R3", "alloc_id", int'(alloc_id), i);
      chk_state("R2", N - 1 - i);
    end
  endtask

  task automatic t_release_two();
    step(0, 1, 2);
    chk("R5", "rel_err", int'(rel_err), 0);
    chk_state("R5", N - 3);
    step(0, 1, 0);
    chk_state("R5", N - 2);
  endtask

  task automatic t_drain();
    for (int i = 0; i < N - 2; i++) begin
      int exp_id;
      if (i < N - 4) exp_id = i + 4;
      else exp_id = (i == N - 4) ? 2 : 0;
      step(1, 0, 0);
      chk("R3", "alloc_id", int'(alloc_id), exp_id);
      chk_state("R2", N - 3 - i);
    end
  endtask

  task automatic t_empty_refuse();
    step(1, 0, 0);
    chk("R4", "alloc_gnt", int'(alloc_gnt), 0);
    chk_state("R4", 0);
  endtask

  task automatic t_double_release();
    step(0, 1, 7);
    chk("R5", "rel_err", int'(rel_err), 0);
    chk_state("R5", 1);
    step(0, 1, 7);
    chk("R7", "rel_err", int'(rel_err), 1);
    chk_state("R7", 1);
    step(1, 0, 0);
    chk("R7", "alloc_id", int'(alloc_id), 7);
    chk_state("R7", 0);
    step(1, 0, 0);
    chk("R7", "alloc_gnt after single requeue", int'(alloc_gnt), 0);
  endtask

  task automatic t_empty_both();
    step(1, 1, 9);
    chk("R4", "alloc_gnt", int'(alloc_gnt), 0);
    chk_state("R4", 1);
    step(1, 0, 0);
    chk("R3", "alloc_id", int'(alloc_id), 9);
    chk_state("R2", 0);
  endtask

  task automatic t_swap();
    step(0, 1, 3);
    chk_state("R5", 1);
    step(1, 1, 5);
    chk("R6", "alloc_gnt", int'(alloc_gnt), 1);
    chk("R6", "alloc_id", int'(alloc_id), 3);
    chk("R6", "rel_err", int'(rel_err), 0);
    chk_state("R6", 1);
    step(1, 0, 0);
    chk("R3", "alloc_id", int'(alloc_id), 5);
    chk_state("R2", 0);
  endtask

  task automatic t_quick_return();
    step(0, 1, 5);
    chk_state("R5", 1);
    step(1, 0, 0);
    chk("R3", "alloc_id", int'(alloc_id), 5);
    step(0, 1, 5);
    chk("R5", "rel_err on quick return", int'(rel_err), 0);
    chk_state("R5", 1);
  endtask

  task automatic t_refill();
    int cnt = 1;
    for (int f = 0; f < N; f++) begin
      if (f != 5) begin
        step(0, 1, f);
        cnt++;
        chk("R9", "rel_err", int'(rel_err), 0);
        chk_state("R5", cnt);
      end
    end
    chk("R9", "ovf_warn at full", int'(ovf_warn), 0);
    step(0, 1, 0);
    chk("R7", "rel_err at full", int'(rel_err), 1);
    chk_state("R9", N);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_allocs();
    t_release_two();
    t_drain();
    t_empty_refuse();
    t_double_release();
    t_empty_both();
    t_swap();
    t_quick_return();
    t_refill();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule